// File: doc/BRIEF.md
# Byte-Bus Instruction Payload Fetcher

This block sits between an 8-bit memory read port and an instruction sequencer. It builds each 16-bit instruction payload from two consecutive byte reads, with the most significant byte at the lower address. It also steps a byte address counter, which a branch can reload. The payload format is fully decided by the two top bits of the first byte. So when that byte shows the three-primitive format, the block offers the payload's first primitive operation to the sequencer at once, before the second byte has arrived.

The sequencer sees one issue port with a valid/ready handshake. A partial offer is flagged as such and carries only the upper byte. A full offer carries the whole payload, and a flag on it tells whether the first primitive operation was already taken from an earlier partial offer, so that the operation is not executed twice. The block holds at most one complete payload, and it stops requesting bytes while that payload waits for the sequencer.

Top module: `byte_payload_fetch`

## Requirements
- R1: After reset is released, `mem_addr` equals the reset address (0 by default), `iss_valid` is low and `mem_req` is high.
- R2: A byte is taken on each clock edge where `mem_req` and `mem_rvalid` are both high. `mem_addr` then rises by one in the next cycle. Otherwise it keeps its value, unless a redirect loads it.
- R3: The first byte taken for a payload appears on `iss_payload[15:8]` and the second byte appears on `iss_payload[7:0]`.
- R4: `iss_fmt` is computed from payload bits 15:14. It is 2 (three primitives) when bit 15 is 1, 0 (two standard ops) when the bits are 00, and 1 (immediate) when the bits are 01.
- R5: When the first byte has bit 15 set, the cycle after that byte is taken shows `iss_valid=1` with `iss_partial=1`. The offer stays until it is accepted or the second byte completes the payload. A partial offer never carries a format other than 2.
- R6: For formats 0 and 1, `iss_valid` stays low after the first byte and first rises in the cycle after the second byte is taken.
- R7: Once a partial offer is accepted, it is not offered again. The full offer that follows carries `iss_first_done=1`. A full offer whose first operation was not taken early carries `iss_first_done=0`.
- R8: While a full payload waits with `iss_ready` low, `mem_req` is low. In that time `mem_addr` and `iss_payload` stay unchanged.
- R9: A `redirect` pulse loads `redirect_addr` into `mem_addr` for the next cycle and takes no byte in its own cycle. It discards any half-built or held payload, so `iss_valid` is low in the next cycle. The next byte taken becomes the upper byte of a new payload.
- R10: A full offer accepted with `iss_ready` frees the buffer. In the next cycle `iss_valid` is low and `mem_req` is high again. Payloads are delivered in address order with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | AW (16) | Byte address of the current request |
| mem_rvalid | input | 1 | Memory delivers `mem_rdata` for `mem_addr` in this cycle |
| mem_rdata | input | BW (8) | Byte read data |
| redirect | input | 1 | Branch: reload the address and drop partial work |
| redirect_addr | input | AW (16) | New byte address on a redirect |
| iss_valid | output | 1 | An offer is present on the issue port |
| iss_ready | input | 1 | Sequencer accepts the current offer |
| iss_partial | output | 1 | Offer holds only the upper byte (early first primitive) |
| iss_first_done | output | 1 | Full offer whose first primitive was already issued |
| iss_fmt | output | 2 | Payload format: 0 standard, 1 immediate, 2 primitive |
| iss_payload | output | 2*BW (16) | Assembled payload; low byte zero on a partial offer |

## Verification
Every result has a fixed latency of one cycle after the clock edge that causes it. This holds for the address step after a taken byte, the partial offer after a primitive upper byte, the full offer after the lower byte, the freed buffer after an accepted full offer, and the reloaded address after a redirect. The bench sets its inputs at a falling edge and lets one rising edge pass. It then sets the inputs back to idle and reads the outputs a moment later, so each check falls exactly in the cycle where its result is due. Two sweeps then run through all 256 upper-byte values, one with steady and one with patterned valid/ready. They check each handshake against payloads and formats computed from the memory model's address arithmetic, and they track whether the partial offer of each payload was accepted.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [1:0] {
    FMT_STD  = 2'd0,
    FMT_IMM  = 2'd1,
    FMT_PRIM = 2'd2
  } fmt_e;

  typedef enum logic [1:0] {
    ASM_EMPTY = 2'd0,
    ASM_HALF  = 2'd1,
    ASM_FULL  = 2'd2
  } asm_state_e;

  // Format select lives in the two most significant payload bits.
  function automatic fmt_e classify(input logic [1:0] sel);
    if (sel[1])      return FMT_PRIM;
    else if (sel[0]) return FMT_IMM;
    else             return FMT_STD;
  endfunction

endpackage

// File: rtl/fetch_addr_ctr.sv
module fetch_addr_ctr #(
  parameter int unsigned AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load | step;
    addr_d  = addr_q;
    if (load)      addr_d = load_addr;
    else if (step) addr_d = addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= RESET_ADDR;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

// File: rtl/payload_asm.sv
module payload_asm
  import fetch_pkg::*;
#(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          take,
  input  logic [BW-1:0] byte_in,
  input  logic          consume,
  output asm_state_e    state,
  output logic [BW-1:0] hi_byte,
  output logic [BW-1:0] lo_byte
);

  asm_state_e    st_q, st_d;
  logic [BW-1:0] hi_q, hi_d, lo_q, lo_d;
  logic          st_en, hi_en, lo_en;

  always_comb begin
    st_d  = st_q;
    hi_d  = hi_q;
    lo_d  = lo_q;
    hi_en = 1'b0;
    lo_en = 1'b0;
    if (flush) begin
      st_d = ASM_EMPTY;
    end else begin
      unique case (st_q)
        ASM_EMPTY: if (take) begin
          hi_d  = byte_in;
          hi_en = 1'b1;
          st_d  = ASM_HALF;
        end
        ASM_HALF: if (take) begin
          lo_d  = byte_in;
          lo_en = 1'b1;
          st_d  = ASM_FULL;
        end
        ASM_FULL: if (consume) st_d = ASM_EMPTY;
        default: st_d = ASM_EMPTY;
      endcase
    end
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ASM_EMPTY;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  assign state   = st_q;
  assign hi_byte = hi_q;
  assign lo_byte = lo_q;

endmodule

// File: rtl/issue_ctl.sv
module issue_ctl
  import fetch_pkg::*;
#(
  parameter int unsigned BW = 8,
  localparam int unsigned PW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  asm_state_e    state,
  input  logic [BW-1:0] hi_byte,
  input  logic [BW-1:0] lo_byte,
  input  logic          iss_ready,
  output logic          iss_valid,
  output logic          iss_partial,
  output logic          iss_first_done,
  output logic [1:0]    iss_fmt,
  output logic [PW-1:0] iss_payload,
  output logic          consume
);

  fmt_e fmt;
  logic early_q, early_d, early_en;
  logic part_offer, full_offer;

  always_comb begin
    fmt        = classify(hi_byte[BW-1 -: 2]);
    part_offer = (state == ASM_HALF) && (fmt == FMT_PRIM) && !early_q;
    full_offer = (state == ASM_FULL);
    consume    = full_offer && iss_ready;
  end

  always_comb begin
    early_d = early_q;
    if (flush || consume)         early_d = 1'b0;
    else if (part_offer && iss_ready) early_d = 1'b1;
    early_en = (early_d != early_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        early_q <= 1'b0;
    else if (early_en) early_q <= early_d;
  end

  assign iss_valid      = part_offer || full_offer;
  assign iss_partial    = part_offer;
  assign iss_first_done = full_offer && early_q;
  assign iss_fmt        = fmt;
  assign iss_payload    = {hi_byte, (full_offer ? lo_byte : {BW{1'b0}})};

endmodule

// File: rtl/byte_payload_fetch.sv
module byte_payload_fetch
  import fetch_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned BW          = 8,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [BW-1:0] mem_rdata,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_addr,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic          iss_partial,
  output logic          iss_first_done,
  output logic [1:0]    iss_fmt,
  output logic [PW-1:0] iss_payload
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  asm_state_e    state;
  logic [BW-1:0] hi_byte, lo_byte;
  logic          take, consume;

  assign mem_req = rst_sync_n && !redirect && (state != ASM_FULL);
  assign take    = mem_req && mem_rvalid;

  fetch_addr_ctr #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_addr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (redirect),
    .load_addr (redirect_addr),
    .step      (take),
    .addr      (mem_addr)
  );

  payload_asm #(.BW(BW)) u_asm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .flush   (redirect),
    .take    (take),
    .byte_in (mem_rdata),
    .consume (consume),
    .state   (state),
    .hi_byte (hi_byte),
    .lo_byte (lo_byte)
  );

  issue_ctl #(.BW(BW)) u_iss (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .flush          (redirect),
    .state          (state),
    .hi_byte        (hi_byte),
    .lo_byte        (lo_byte),
    .iss_ready      (iss_ready),
    .iss_valid      (iss_valid),
    .iss_partial    (iss_partial),
    .iss_first_done (iss_first_done),
    .iss_fmt        (iss_fmt),
    .iss_payload    (iss_payload),
    .consume        (consume)
  );

endmodule

// File: rtl/byte_payload_fetch_chk.sv
module byte_payload_fetch_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_rvalid,
  input logic            redirect,
  input logic [AW-1:0]   redirect_addr,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic            iss_partial,
  input logic [1:0]      iss_fmt,
  input logic [2*BW-1:0] iss_payload
);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid) |=> (mem_addr == AW'($past(mem_addr) + AW'(1))));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mem_req && mem_rvalid) && !redirect) |=> $stable(mem_addr));

  p_partial_prim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_partial) |-> (iss_fmt == 2'd2));

  p_no_reissue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_partial && iss_ready && !redirect) |=> !(iss_valid && iss_partial));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_partial && !iss_ready && !redirect)
      |=> (iss_valid && !iss_partial && $stable(iss_payload) && $stable(mem_addr)));

  p_stall_noreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_partial) |-> !mem_req);

  p_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!iss_valid && (mem_addr == $past(redirect_addr))));

endmodule

bind byte_payload_fetch byte_payload_fetch_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_rvalid    (mem_rvalid),
  .redirect      (redirect),
  .redirect_addr (redirect_addr),
  .iss_valid     (iss_valid),
  .iss_ready     (iss_ready),
  .iss_partial   (iss_partial),
  .iss_fmt       (iss_fmt),
  .iss_payload   (iss_payload)
);

// File: tb/tb_byte_payload_fetch.sv
module tb_byte_payload_fetch;

  localparam int AW = 16;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid;
  logic [BW-1:0] mem_rdata;
  logic          redirect;
  logic [AW-1:0] redirect_addr;
  logic          iss_valid, iss_ready, iss_partial, iss_first_done;
  logic [1:0]    iss_fmt;
  logic [15:0]   iss_payload;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  // Memory model: even address 2k holds k, odd address holds k ^ A5.
  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[0] ? (a[8:1] ^ 8'hA5) : a[8:1];
  endfunction

  function automatic logic [1:0] exp_fmt(input logic [7:0] hi);
    return hi[7] ? 2'd2 : (hi[6] ? 2'd1 : 2'd0);
  endfunction

  assign mem_rdata = mem_byte(mem_addr);

  byte_payload_fetch dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .mem_rvalid     (mem_rvalid),
    .mem_rdata      (mem_rdata),
    .redirect       (redirect),
    .redirect_addr  (redirect_addr),
    .iss_valid      (iss_valid),
    .iss_ready      (iss_ready),
    .iss_partial    (iss_partial),
    .iss_first_done (iss_first_done),
    .iss_fmt        (iss_fmt),
    .iss_payload    (iss_payload)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic rd, input logic rdr, input logic [AW-1:0] ra);
    mem_rvalid    = rv;
    iss_ready     = rd;
    redirect      = rdr;
    redirect_addr = ra;
  endtask

  // One rising edge with the driven inputs, then idle inputs and settle.
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, '0);
    #1;
  endtask

  task automatic go(input logic rv, input logic rd, input logic rdr, input logic [AW-1:0] ra);
    drive(rv, rd, rdr, ra);
    cycle();
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic sweep(input bit patterned);
    int got;
    bit seen;
    logic [AW-1:0] e;
    got  = 0;
    seen = 1'b0;
    e    = '0;
    go(1'b1, 1'b0, 1'b1, '0);
    for (int k = 0; k < 6000 && got < 256; k++) begin
      mem_rvalid = patterned ? ((k % 3) != 1) : 1'b1;
      iss_ready  = patterned ? ((k % 5) != 2) : 1'b1;
      #1;
      if (iss_valid && iss_ready) begin
        if (iss_partial) begin
          chk(iss_fmt == 2'd2 && iss_payload[15:8] == mem_byte(e), "R5 sweep partial",
              {iss_fmt, iss_payload}, {exp_fmt(mem_byte(e)), mem_byte(e), 8'h00});
          chk(!seen, "R7 sweep single partial", 32'(seen), 0);
          seen = 1'b1;
        end else begin
          chk(iss_payload == {mem_byte(e), mem_byte(e + 1)}, "R3 sweep payload",
              iss_payload, {mem_byte(e), mem_byte(e + 1)});
          chk(iss_fmt == exp_fmt(mem_byte(e)), "R4 sweep format", iss_fmt, exp_fmt(mem_byte(e)));
          chk(iss_first_done == seen, "R7 sweep first_done", iss_first_done, seen);
          e    = e + 2;
          seen = 1'b0;
          got++;
        end
      end
      @(posedge clk);
      @(negedge clk);
    end
    drive(1'b0, 1'b0, 1'b0, '0);
    chk(got == 256, "R10 sweep count", got, 256);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, '0);
    repeat (3) @(negedge clk);
    #1;
    chk(iss_valid == 1'b0 && mem_addr == '0, "R1 during reset", {iss_valid, mem_addr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state after release
    chk(mem_addr == '0, "R1 addr", mem_addr, 0);
    chk(iss_valid == 1'b0, "R1 valid", iss_valid, 0);
    chk(mem_req == 1'b1, "R1 req", mem_req, 1);

    // Primitive payload at 0x100: hi 0x80, lo 0x25; early offer accepted alone.
    go(1'b1, 1'b0, 1'b1, 16'h0100);
    chk(mem_addr == 16'h0100 && !iss_valid, "R9 redirect load", {iss_valid, mem_addr}, 16'h0100);
    go(1'b1, 1'b0, 1'b0, '0);
    chk(iss_valid && iss_partial, "R5 early offer", {iss_valid, iss_partial}, 2'b11);
    chk(iss_payload[15:8] == 8'h80, "R3 upper byte", iss_payload[15:8], 8'h80);
    chk(iss_fmt == 2'd2, "R4 prim format", iss_fmt, 2);
    chk(mem_addr == 16'h0101, "R2 step", mem_addr, 16'h0101);
    go(1'b0, 1'b0, 1'b0, '0);
    chk(iss_valid && iss_partial && mem_addr == 16'h0101, "R5 offer held", {iss_valid, iss_partial, mem_addr}, {2'b11, 16'h0101});
    go(1'b0, 1'b1, 1'b0, '0);
    chk(!iss_valid, "R7 no reoffer", iss_valid, 0);
    go(1'b1, 1'b0, 1'b0, '0);
    chk(iss_valid && !iss_partial && iss_first_done, "R7 first_done", {iss_valid, iss_partial, iss_first_done}, 3'b101);
    chk(iss_payload == 16'h8025, "R3 full payload", iss_payload, 16'h8025);
    chk(mem_addr == 16'h0102 && !mem_req, "R8 stall no req", {mem_req, mem_addr}, 16'h0102);
    repeat (3) go(1'b1, 1'b0, 1'b0, '0);
    chk(mem_addr == 16'h0102 && iss_payload == 16'h8025 && iss_valid, "R8 stall hold",
        {iss_valid, mem_addr, iss_payload}, {1'b1, 16'h0102, 16'h8025});
    go(1'b0, 1'b1, 1'b0, '0);
    chk(!iss_valid && mem_req, "R10 buffer freed", {iss_valid, mem_req}, 2'b01);

    // Standard payload at 0x20: hi 0x10, lo 0xB5.
    go(1'b0, 1'b0, 1'b1, 16'h0020);
    go(1'b1, 1'b1, 1'b0, '0);
    chk(!iss_valid, "R6 std no early", iss_valid, 0);
    go(1'b1, 1'b0, 1'b0, '0);
    chk(iss_valid && !iss_partial && !iss_first_done && iss_fmt == 2'd0 && iss_payload == 16'h10B5,
        "R6 std full", {iss_valid, iss_partial, iss_first_done, iss_fmt, iss_payload}, {5'b10000, 16'h10B5});

    // Immediate payload at 0xA0: hi 0x50, lo 0xF5.
    go(1'b0, 1'b0, 1'b1, 16'h00A0);
    go(1'b1, 1'b1, 1'b0, '0);
    chk(!iss_valid, "R6 imm no early", iss_valid, 0);
    go(1'b1, 1'b0, 1'b0, '0);
    chk(iss_valid && iss_fmt == 2'd1 && iss_payload == 16'h50F5 && !iss_first_done,
        "R6 imm full", {iss_valid, iss_fmt, iss_first_done, iss_payload}, {4'b1010, 16'h50F5});

    // Primitive at 0x186 (hi C3, lo 66): early offer never taken.
    go(1'b0, 1'b0, 1'b1, 16'h0186);
    go(1'b1, 1'b0, 1'b0, '0);
    go(1'b1, 1'b0, 1'b0, '0);
    chk(iss_valid && !iss_partial && !iss_first_done && iss_payload == 16'hC366,
        "R7 not taken early", {iss_valid, iss_partial, iss_first_done, iss_payload}, {3'b100, 16'hC366});
    // Redirect while full discards it.
    go(1'b1, 1'b0, 1'b1, 16'h0020);
    chk(!iss_valid && mem_addr == 16'h0020, "R9 drop full", {iss_valid, mem_addr}, 16'h0020);

    // Early offer accepted in the same cycle as the lower byte arrives.
    go(1'b0, 1'b0, 1'b1, 16'h0186);
    go(1'b1, 1'b0, 1'b0, '0);
    go(1'b1, 1'b1, 1'b0, '0);
    chk(iss_valid && !iss_partial && iss_first_done, "R7 same-cycle take", {iss_valid, iss_partial, iss_first_done}, 3'b101);

    // Redirect mid-payload: half payload dropped, next byte is a new upper byte.
    go(1'b0, 1'b1, 1'b1, 16'h0020);
    go(1'b1, 1'b0, 1'b0, '0);
    go(1'b1, 1'b0, 1'b1, 16'h0100);
    chk(!iss_valid && mem_addr == 16'h0100, "R9 drop half", {iss_valid, mem_addr}, 16'h0100);
    go(1'b1, 1'b0, 1'b0, '0);
    chk(iss_valid && iss_partial && iss_payload[15:8] == 8'h80, "R9 fresh upper", {iss_valid, iss_partial, iss_payload[15:8]}, {2'b11, 8'h80});

    sweep(1'b0);
    sweep(1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule